// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns the code-fetch and data-access requests of a small 8-bit controller core into the timing of a multiplexed external memory bus. It runs on the oscillator clock. A machine cycle of twelve clocks is split into six states of two clocks each. Every machine cycle is one of three kinds: an external fetch cycle with two code-byte reads, a data cycle with one read or write, or a cycle with no bus strobe (an internal fetch or an idle cycle).

The low address byte and the data byte share one byte-wide port. The address is presented while the address-latch strobe is high. The data byte follows on the same pins: driven by the block for writes and sampled from the pins for reads. A second port carries the high address byte. For an 8-bit-address data access it carries the core's port-2 register value instead. The external-access strap is latched when reset is released. Together with the program counter, it decides whether a fetch goes to the bus or is served internally.

The reset input is filtered, so it takes effect only after it has been held high for two full machine cycles.

Top module: `xbus_seq`

## Requirements
- R1: The internal reset becomes active only after `rst_in` has been high on 24 consecutive clock edges. A pulse of 23 edges has no effect, and address-latch pulses keep coming. While the internal reset is active, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, and `p0_oe` and `p2_oe` are low.
- R2: Phases are numbered 0 to 11 from the first clock of a machine cycle. In every cycle that is not a data cycle, `ale` is high exactly in phases 0, 1, 6 and 7 (bit i of the 12-bit pattern is phase i: 0x0C3).
- R3: In a data cycle, `ale` is high only in phases 0 and 1 (pattern 0x003), so one pulse is dropped. For a read, `rd_n` is low in phases 2 to 9 (high pattern 0xC03). For a write, `wr_n` shows that same pattern. The other strobe stays high.
- R4: In an external fetch cycle, `psen_n` is low in phases 2–5 and 8–11 (high pattern 0x0C3). In data cycles, internal fetches, idle cycles and reset, `psen_n` stays high.
- R5: `p0_oe` is high while a bus address is presented: phases 0–1 of data cycles, and phases 0–1 and 6–7 of external fetches. For a write, it stays high for the whole cycle with `wdata` on `p0_out` from phase 2. It is low during every read strobe and in internal or idle cycles. `p0_out` carries the low address byte during the address phases.
- R6: The high address output `p2_out` is valid with `p2_oe` high during bus cycles. It shows the fetch address high byte for fetches and `daddr[15:8]` for data cycles with `dwide`=1. For `dwide`=0 it shows the `p2_reg` value sampled when the cycle was accepted.
- R7: When the latched strap is 1, a fetch with `pc` < 16384 is internal. Such a fetch has `int_fetch` high, no `psen_n` pulse and no port drive. A fetch with `pc` >= 16384 is external. When the latched strap is 0, every fetch is external.
- R8: A fetch cycle reads `pc` in the first half and `pc`+1 in the second half. Code bytes are captured from `p0_in` on the clock edges at the ends of phases 5 and 11. Each capture pulses `code_valid` for one clock with the byte on `cap_byte`. A read captures on the edge that ends phase 9 and pulses `data_valid`.
- R9: `ea_in` is sampled only on the edge that releases the internal reset. Changes afterwards, and reset pulses too short to act, leave the fetch routing unchanged.
- R10: Requests are sampled on the edge ending phase 11. `dreq` has priority over `fetch_req`. An accepted request pulses `taken` in phase 0 of the cycle that serves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Raw reset, active high, filtered |
| ea_in | input | 1 | External-access strap level |
| fetch_req | input | 1 | Core requests a code fetch cycle |
| pc | input | 16 | Fetch address |
| dreq | input | 1 | Core requests a data cycle |
| dwrite | input | 1 | 1 = write, 0 = read |
| dwide | input | 1 | 1 = 16-bit address form, 0 = 8-bit form |
| daddr | input | 16 | Data address |
| wdata | input | 8 | Write data |
| p2_reg | input | 8 | Port-2 register contents |
| p0_in | input | 8 | Low port pin levels |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low port drive value |
| p0_oe | output | 1 | Low port drive enable |
| p2_out | output | 8 | High port drive value |
| p2_oe | output | 1 | High port drive enable |
| cap_byte | output | 8 | Last captured byte |
| code_valid | output | 1 | Code byte captured |
| data_valid | output | 1 | Read byte captured |
| taken | output | 1 | Request accepted, phase 0 |
| int_fetch | output | 1 | Current cycle is an internal fetch |

## Verification
A wrong phase count or cycle kind appears at the strobes within one machine cycle. It shows as an address-latch pattern other than 0x0C3 or 0x003, or as a read strobe misplaced by a phase. A stale latched address, strap or port-2 value shows on the high port at phase 0 of the next bus cycle. It also corrupts the captured byte two to five states later, because the bench's memory answers each latched address with a distinct byte. A reset filter that counts wrongly shows within one reset pulse: address-latch pulses either continue through the long hold or stop during the 23-edge pulse.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int CLKS_PER_STATE = 2,
  parameter int STATES         = 6,
  parameter int RST_MCYC       = 2,
  parameter int ROM_TOP        = 16384
) (
  input  logic        clk,
  input  logic        rst_in,
  input  logic        ea_in,
  input  logic        fetch_req,
  input  logic [15:0] pc,
  input  logic        dreq,
  input  logic        dwrite,
  input  logic        dwide,
  input  logic [15:0] daddr,
  input  logic [7:0]  wdata,
  input  logic [7:0]  p2_reg,
  input  logic [7:0]  p0_in,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  p0_out,
  output logic        p0_oe,
  output logic [7:0]  p2_out,
  output logic        p2_oe,
  output logic [7:0]  cap_byte,
  output logic        code_valid,
  output logic        data_valid,
  output logic        taken,
  output logic        int_fetch
);
  localparam int MC       = CLKS_PER_STATE * STATES;
  localparam int PW       = $clog2(MC);
  localparam int SW       = $clog2(STATES);
  localparam int RST_CLKS = RST_MCYC * MC;
  localparam int RCW      = $clog2(RST_CLKS);
  localparam logic [PW-1:0] LAST   = PW'(MC - 1);
  localparam logic [PW-1:0] F1_END = PW'(3 * CLKS_PER_STATE - 1);
  localparam logic [PW-1:0] RD_END = PW'(5 * CLKS_PER_STATE - 1);
  localparam logic [1:0] K_IDLE = 2'd0, K_FI = 2'd1, K_FX = 2'd2, K_DAT = 2'd3;

  logic [RCW-1:0] rcnt;
  logic           rst_int, ea_lat;
  logic [PW-1:0]  ph;
  logic [SW-1:0]  st;
  logic [1:0]     cyc;
  logic [15:0]    pcl, a, faddr;
  logic [7:0]     wd, p2l;
  logic           wr, wide, dat, fx, live;

  always_ff @(posedge clk) begin
    if (!rst_in) rcnt <= '0;
    else if (rcnt != RCW'(RST_CLKS - 1)) rcnt <= rcnt + 1'b1;
    rst_int <= rst_in & (rst_int | (rcnt == RCW'(RST_CLKS - 1)));
    if (rst_int & !rst_in) ea_lat <= ea_in;
  end

  always_ff @(posedge clk) begin
    if (rst_int) begin
      ph <= '0;
      cyc <= K_IDLE;
      taken <= 1'b0;
      code_valid <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      ph <= (ph == LAST) ? '0 : ph + 1'b1;
      taken <= 1'b0;
      code_valid <= 1'b0;
      data_valid <= 1'b0;
      if (ph == LAST) begin
        if (dreq) begin
          cyc <= K_DAT;
          a <= daddr;
          wr <= dwrite;
          wide <= dwide;
          wd <= wdata;
          p2l <= p2_reg;
          taken <= 1'b1;
        end else if (fetch_req) begin
          cyc <= (!ea_lat || 32'(pc) >= ROM_TOP) ? K_FX : K_FI;
          pcl <= pc;
          taken <= 1'b1;
        end else begin
          cyc <= K_IDLE;
        end
      end
      if (dat && !wr && ph == RD_END) begin
        cap_byte <= p0_in;
        data_valid <= 1'b1;
      end
      if (fx && (ph == F1_END || ph == LAST)) begin
        cap_byte <= p0_in;
        code_valid <= 1'b1;
      end
    end
  end

  assign st        = SW'(ph / PW'(CLKS_PER_STATE));
  assign live      = !rst_int;
  assign dat       = cyc == K_DAT;
  assign fx        = cyc == K_FX;
  assign int_fetch = live && cyc == K_FI;
  assign faddr     = pcl + 16'(st >= SW'(3));
  assign ale       = live && (st == '0 || (st == SW'(3) && !dat));
  assign psen_n    = !(live && fx && st != '0 && st != SW'(3));
  assign rd_n      = !(live && dat && !wr && st >= SW'(1) && st <= SW'(4));
  assign wr_n      = !(live && dat && wr && st >= SW'(1) && st <= SW'(4));
  assign p0_oe     = live && ((ale && (fx || dat)) || (dat && wr));
  assign p0_out    = fx ? faddr[7:0] : (dat && st != '0) ? wd : a[7:0];
  assign p2_oe     = live && (fx || dat);
  assign p2_out    = fx ? faddr[15:8] : !dat ? p2_reg : wide ? a[15:8] : p2l;

  AST_RST_QUIET: assert property (@(posedge clk)
    rst_int |-> (!ale && psen_n && rd_n && wr_n && !p0_oe && !p2_oe)); // R1
  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (rst_int)
    $rose(ale) |=> ale); // R2
  AST_ALE_QUIET: assert property (@(posedge clk) disable iff (rst_int)
    (!rd_n || !wr_n) |-> !ale); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst_int)
    $onehot0({!psen_n, !rd_n, !wr_n})); // R4
  AST_P0_FLOAT: assert property (@(posedge clk) disable iff (rst_int)
    (!rd_n || !psen_n) |-> !p0_oe); // R5
  AST_DATA_CAP: assert property (@(posedge clk) disable iff (rst_int)
    data_valid |-> (rd_n && !$past(rd_n))); // R8
  AST_CODE_CAP: assert property (@(posedge clk) disable iff (rst_int)
    code_valid |-> (psen_n && !$past(psen_n))); // R8
  AST_EA_HOLD: assert property (@(posedge clk) disable iff (rst_int)
    !$past(rst_int) |-> $stable(ea_lat)); // R9
  AST_TAKEN_PH0: assert property (@(posedge clk) disable iff (rst_int)
    taken |-> (ale && $past(ale) == 1'b0)); // R10
endmodule

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_in = 1'b1, ea_in = 1'b1, fetch_req = 1'b0, dreq = 1'b0, dwrite = 1'b0, dwide = 1'b0;
  logic [15:0] pc = '0, daddr = '0, lat = '0;
  logic [7:0]  wdata = '0, p2_reg = '0, p0_in;
  logic ale, psen_n, rd_n, wr_n, p0_oe, p2_oe, code_valid, data_valid, taken, int_fetch;
  logic [7:0] p0_out, p2_out, cap_byte;

  xbus_seq u0 (.*);

  int total = 0, bad = 0, mgot = 0;
  int exp_q[$];

  function automatic logic [7:0] mem(input logic [15:0] ad);
    return ad[7:0] ^ {ad[14:8], ad[15]} ^ 8'hA5;
  endfunction

  assign p0_in = mem(lat);
  always @(negedge clk) if (ale) lat <= {p2_out, p0_out};

  task automatic chk(input string tag, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (code_valid || data_valid) begin
      mgot = {23'd0, data_valid, cap_byte};
      if (exp_q.size() == 0) chk("R8", "unexpected capture", mgot, -1);
      else chk("R8", "captured byte", mgot, exp_q.pop_front());
    end
  end

  task automatic run(input int kind, input logic [15:0] adr, input logic wide,
                     input logic [7:0] wd, input logic [7:0] p2r, input logic ext);
    logic [11:0] va, vp, vr, vw, vo;
    logic [7:0]  p2a, p0a, p2b, p0b, p0w, p2x;
    logic        intf, p2e;
    logic [15:0] a1;
    a1 = adr + 16'd1;
    pc = adr; daddr = adr; dwide = wide; wdata = wd; p2_reg = p2r;
    if (kind == 0) begin
      fetch_req = 1'b1;
      if (ext) begin exp_q.push_back({24'd0, mem(adr)}); exp_q.push_back({24'd0, mem(a1)}); end
    end else begin
      dreq = 1'b1;
      dwrite = (kind == 2);
      p2x = wide ? adr[15:8] : p2r;
      if (kind == 1) exp_q.push_back({23'd0, 1'b1, mem({p2x, adr[7:0]})});
    end
    do @(negedge clk); while (!taken);
    fetch_req = 1'b0; dreq = 1'b0; p2_reg = 8'h00;
    for (int i = 0; i < 12; i++) begin
      if (i > 0) @(negedge clk);
      va[i] = ale; vp[i] = psen_n; vr[i] = rd_n; vw[i] = wr_n; vo[i] = p0_oe;
      if (i == 0) begin p2a = p2_out; p0a = p0_out; p2e = p2_oe; intf = int_fetch; end
      if (i == 5) p0w = p0_out;
      if (i == 6) begin p2b = p2_out; p0b = p0_out; end
    end
    if (kind == 0) begin
      chk("R2", "ale pattern fetch", va, 12'h0C3);
      chk("R4", "psen pattern", vp, ext ? 12'h0C3 : 12'hFFF);
      chk("R3", "rd idle in fetch", vr, 12'hFFF);
      chk("R3", "wr idle in fetch", vw, 12'hFFF);
      chk("R5", "p0_oe fetch", vo, ext ? 12'h0C3 : 12'h000);
      chk("R7", "int_fetch", intf, !ext);
      chk("R6", "p2_oe fetch", p2e, ext);
      if (ext) begin
        chk("R6", "p2 first addr", p2a, adr[15:8]);
        chk("R5", "p0 first addr", p0a, adr[7:0]);
        chk("R6", "p2 second addr", p2b, a1[15:8]);
        chk("R8", "p0 second addr", p0b, a1[7:0]);
      end
    end else begin
      chk("R3", "ale pattern data", va, 12'h003);
      chk("R4", "psen in data", vp, 12'hFFF);
      chk("R3", "rd pattern", vr, kind == 1 ? 12'hC03 : 12'hFFF);
      chk("R3", "wr pattern", vw, kind == 2 ? 12'hC03 : 12'hFFF);
      chk("R5", "p0_oe data", vo, kind == 2 ? 12'hFFF : 12'h003);
      chk("R5", "p0 data addr", p0a, adr[7:0]);
      chk("R6", "p2 data addr", p2a, wide ? adr[15:8] : p2r);
      chk("R6", "p2_oe data", p2e, 1);
      if (kind == 2) chk("R5", "write data", p0w, wd);
    end
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    finish_up();
  end

  initial begin
    int n;
    repeat (30) @(negedge clk);
    chk("R1", "ale in reset", ale, 0);
    chk("R1", "psen in reset", psen_n, 1);
    chk("R1", "p0_oe in reset", p0_oe, 0);
    rst_in = 1'b0;
    repeat (3) @(negedge clk);
    run(0, 16'h1234, 0, 8'h00, 8'h00, 0);
    run(0, 16'h3FFF, 0, 8'h00, 8'h00, 0);
    run(0, 16'h4000, 0, 8'h00, 8'h00, 1);
    run(0, 16'hFFFF, 0, 8'h00, 8'h00, 1);
    run(1, 16'hA55A, 1, 8'h00, 8'h11, 0);
    run(1, 16'h9977, 0, 8'h00, 8'hC3, 0);
    run(2, 16'h1281, 1, 8'h3C, 8'h00, 0);
    run(2, 16'h5501, 0, 8'hE7, 8'h6B, 0);
    fetch_req = 1'b1; dreq = 1'b1; pc = 16'h8000; daddr = 16'h0042; dwrite = 1'b0; dwide = 1'b1;
    exp_q.push_back({23'd0, 1'b1, mem(16'h0042)});
    do @(negedge clk); while (!taken);
    fetch_req = 1'b0; dreq = 1'b0;
    chk("R10", "dreq priority, psen", psen_n, 1);
    repeat (3) @(negedge clk);
    chk("R10", "dreq priority, rd", rd_n, 0);
    repeat (8) @(negedge clk);
    ea_in = 1'b0;
    run(0, 16'h2000, 0, 8'h00, 8'h00, 0);
    rst_in = 1'b1; n = 0;
    repeat (23) begin @(negedge clk); if (ale) n++; end
    rst_in = 1'b0;
    chk("R1", "ale kept through 23-edge pulse", n >= 6, 1);
    run(0, 16'h2000, 0, 8'h00, 8'h00, 0);
    rst_in = 1'b1; n = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (i >= 26 && (ale || !psen_n)) n++;
    end
    chk("R1", "bus quiet after long hold", n, 0);
    rst_in = 1'b0;
    @(negedge clk);
    ea_in = 1'b1;
    run(0, 16'h0100, 0, 8'h00, 8'h00, 1);
    run(0, 16'h3FFF, 0, 8'h00, 8'h00, 1);
    repeat (20) @(negedge clk);
    chk("R8", "all captures seen", exp_q.size(), 0);
    finish_up();
  end
endmodule